// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Refresh and Unlock

This block is a watchdog timer that sits on a simple register bus. A 16-bit counter advances on ticks from one of four clock-enable sources, either directly or through a divide-by-256 prescaler. Software keeps the system alive by writing a 32-bit refresh key to the counter register. In 32-bit command mode the key arrives as a single write. Otherwise it arrives as two 16-bit writes, low half first and high half second. If the counter reaches the programmed timeout, or software writes a bad key, the block trips.

The control, timeout and window registers are write-once after reset. Each may be rewritten only if the update-permit bit is set in the control register. Software must then write a 32-bit unlock key to the counter register, which opens a configuration window of 128 bus clocks. Within that window each register accepts one write.

When the watchdog trips with its interrupt enabled, it raises a flag and an interrupt request, then raises the reset request 128 bus clocks later. With the interrupt disabled, the reset request rises at once. The reset request stays high until the block's own reset.

Top module: `kww_top`

## Requirements
- R1: After reset: control reads 0x0009, timeout reads 0xFFFF, window reads 0, counter reads 0, status reads 0x1, and irq and rst_req are low. Register addresses are control 0, counter 1, timeout 2, window 3, status 4. Status bit 0 is running, bit 1 is the flag and bit 2 is config-window-open.
- R2: The first write to control, timeout or window after reset is accepted. A later write is ignored unless update-permit (control bit 3) is set, an unlock has been done, and the configuration window is open.
- R3: While enabled (control bit 0), the counter advances by one per tick of the source chosen by control bits 7:6. Ticks on other sources have no effect. While disabled, the counter holds and status bit 0 reads 0.
- R4: When control bit 4 is 0, the refresh key 0x6B9F0471 is written to the counter register as 0x0471 followed by 0x6B9F. The second half clears the counter, and the first half alone leaves the counter unchanged.
- R5: The unlock key 0xC3A51E2D, written by the same rule as the refresh key, opens a configuration window. A register write is accepted on the 128th clock after the unlock write. Only the first write to each register inside one window is accepted.
- R6: A write made after the configuration window has closed is ignored, and status bit 2 reads 0.
- R7: With control bit 5 set, the counter advances once per 256 ticks of the selected source.
- R8: While the wait, stop or debug mode input is high, the counter advances only if its permit bit is set. The permit bits are control bit 8 for wait, bit 9 for stop and bit 10 for debug.
- R9: Once the counter equals the timeout value, the flag sets on the next clock. With the interrupt enabled (control bit 1), irq rises with the flag. Writing 1 to status bit 1 clears the flag.
- R10: With the interrupt enabled, rst_req rises 128 clocks after the flag sets, even if the flag has been cleared. With the interrupt disabled, rst_req rises on the clock of the trip. rst_req then stays high.
- R11: When enabled, the watchdog trips on the clock of any of these writes to the counter register:
  - a value that starts neither key;
  - a second half that does not match the first half.
- R12: With window mode on (control bit 2), a refresh is an error and trips the watchdog if the counter is below the window value. A refresh with the counter equal to or above the window value is accepted.
- R13: With control bit 4 set, a single 32-bit write of the full key value refreshes or unlocks. Any other value written in this mode is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| clk_ticks | input | 4 | Counting enables, one for each selectable source |
| in_wait | input | 1 | System is in wait mode |
| in_stop | input | 1 | System is in stop mode |
| in_debug | input | 1 | System is halted for debug |
| irq | output | 1 | Interrupt request before the reset |
| rst_req | output | 1 | Reset request, sticky |

## Verification
The assertions check several rules on every cycle:
- the counter is frozen while the watchdog is disabled;
- an accepted refresh leaves a zero count;
- the configuration window opens only after an unlock;
- rst_req is sticky;
- an unmasked key error raises rst_req on the next edge;
- irq never rises after the reset request.

Other behaviours can only be shown by the bench's directed scenarios:
- the exact 128-clock boundaries of the configuration window and the reset delay;
- the prescale ratio;
- the permit bits for each power mode;
- the write-once rejections;
- the window-mode boundary at a count equal to the window value.

// File: rtl/kww_pkg.sv
package kww_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 1 << SEL_W;
    localparam int N_CFG  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_CNT  = 3'd1,
        A_TOV  = 3'd2,
        A_WIN  = 3'd3,
        A_STAT = 3'd4
    } reg_addr_e;

    // control register layout, bit 0 at the bottom
    typedef struct packed {
        logic [2:0]       rsvd;
        logic [1:0]       test_mode;
        logic             dbg_en;
        logic             stop_en;
        logic             wait_en;
        logic [SEL_W-1:0] clk_sel;
        logic             pre256;
        logic             cmd32;
        logic             upd_en;
        logic             win_en;
        logic             int_en;
        logic             en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = ctrl_t'(16'h0009);

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_REF_HI,
        KS_UNL_HI
    } key_state_e;

    typedef struct packed {
        logic refresh;
        logic unlock;
        logic err;
    } key_evt_t;

    function automatic ctrl_t ctrl_from_bus(input logic [15:0] d);
        ctrl_t c;
        c      = ctrl_t'(d);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/kww_keycheck.sv
module kww_keycheck
    import kww_pkg::*;
#(
    parameter logic [31:0] REF_KEY = 32'h6B9F_0471,
    parameter logic [31:0] UNL_KEY = 32'hC3A5_1E2D
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd32,
    input  logic        kwr,
    input  logic [31:0] kdata,
    output key_evt_t    evt
);
    localparam logic [15:0] REF_LO = REF_KEY[15:0];
    localparam logic [15:0] REF_HI = REF_KEY[31:16];
    localparam logic [15:0] UNL_LO = UNL_KEY[15:0];
    localparam logic [15:0] UNL_HI = UNL_KEY[31:16];

    key_state_e st, st_n;

    always_comb begin
        evt  = '0;
        st_n = st;
        if (kwr) begin
            if (cmd32) begin
                st_n = KS_IDLE;
                if (kdata == REF_KEY)      evt.refresh = 1'b1;
                else if (kdata == UNL_KEY) evt.unlock  = 1'b1;
                else                       evt.err     = 1'b1;
            end else begin
                case (st)
                    KS_IDLE: begin
                        if (kdata[15:0] == REF_LO)      st_n = KS_REF_HI;
                        else if (kdata[15:0] == UNL_LO) st_n = KS_UNL_HI;
                        else                            evt.err = 1'b1;
                    end
                    KS_REF_HI: begin
                        st_n = KS_IDLE;
                        if (kdata[15:0] == REF_HI) evt.refresh = 1'b1;
                        else                       evt.err     = 1'b1;
                    end
                    KS_UNL_HI: begin
                        st_n = KS_IDLE;
                        if (kdata[15:0] == UNL_HI) evt.unlock = 1'b1;
                        else                       evt.err    = 1'b1;
                    end
                    default: st_n = KS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= KS_IDLE;
        else     st <= st_n;
    end

endmodule

// File: rtl/kww_counter.sv
module kww_counter #(
    parameter int N_SRC   = 4,
    parameter int PRE_DIV = 256,
    parameter int CNT_W   = 16,
    parameter int SEL_W   = $clog2(N_SRC),
    parameter int PRE_W   = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    input  logic             pre_on,
    input  logic             run,
    input  logic             clear,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic tick;
    logic step;

    assign tick = ticks[sel];

    generate
        if (PRE_DIV > 1) begin : g_pre
            logic [PRE_W-1:0] pcnt;
            logic             pwrap;
            assign pwrap = (pcnt == PRE_W'(PRE_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst || clear)                       pcnt <= '0;
                else if (run && tick && pre_on && !hold) pcnt <= pwrap ? '0 : pcnt + 1'b1;
            end
            assign step = run && tick && !hold && (!pre_on || pwrap);
        end else begin : g_nopre
            assign step = run && tick && !hold;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear)              cnt <= '0;
        else if (step && cnt < limit)  cnt <= cnt + 1'b1;
    end

    assign hit = (cnt >= limit);

endmodule

// File: rtl/kww_cfg.sv
module kww_cfg
    import kww_pkg::*;
#(
    parameter int CFG_WIN = 128,
    parameter int WIN_W   = $clog2(CFG_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              unlock,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  tov,
    output logic [CNT_W-1:0]  win,
    output logic              cfg_open
);
    logic [N_CFG-1:0] sel_reg;
    logic [N_CFG-1:0] done_once;
    logic [N_CFG-1:0] done_win;
    logic [N_CFG-1:0] take;
    logic [WIN_W-1:0] left;

    assign cfg_open = (left != '0);

    always_comb begin
        sel_reg[0] = wr && (addr == A_CTRL);
        sel_reg[1] = wr && (addr == A_TOV);
        sel_reg[2] = wr && (addr == A_WIN);
    end

    generate
        for (genvar i = 0; i < N_CFG; i++) begin : g_take
            assign take[i] = sel_reg[i] &&
                (!done_once[i] || (ctrl.upd_en && cfg_open && !done_win[i]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RST;
            tov       <= '1;
            win       <= '0;
            done_once <= '0;
            done_win  <= '0;
            left      <= '0;
        end else begin
            if (unlock) begin
                left     <= WIN_W'(CFG_WIN);
                done_win <= '0;
            end else begin
                if (left != '0) left <= left - 1'b1;
                done_win <= done_win | take;
            end
            done_once <= done_once | take;
            if (take[0]) ctrl <= ctrl_from_bus(wdata);
            if (take[1]) tov  <= wdata[CNT_W-1:0];
            if (take[2]) win  <= wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/kww_trip.sv
module kww_trip #(
    parameter int RST_DLY = 128,
    parameter int DLY_W   = $clog2(RST_DLY)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic int_en,
    input  logic hit,
    input  logic err,
    input  logic flag_clr,
    output logic flag,
    output logic rst_req,
    output logic tripped
);
    logic             arming;
    logic [DLY_W-1:0] dly;
    logic             fire;

    assign fire = en && !tripped && (hit || err);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            rst_req <= 1'b0;
            tripped <= 1'b0;
            arming  <= 1'b0;
            dly     <= '0;
        end else if (fire) begin
            tripped <= 1'b1;
            if (int_en) begin
                flag   <= 1'b1;
                arming <= 1'b1;
                dly    <= DLY_W'(RST_DLY - 1);
            end else begin
                rst_req <= 1'b1;
            end
        end else begin
            if (flag_clr) flag <= 1'b0;
            if (arming) begin
                if (dly == '0) begin
                    rst_req <= 1'b1;
                    arming  <= 1'b0;
                end else begin
                    dly <= dly - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/kww_top.sv
module kww_top
    import kww_pkg::*;
#(
    parameter logic [31:0] REF_KEY = 32'h6B9F_0471,
    parameter logic [31:0] UNL_KEY = 32'hC3A5_1E2D,
    parameter int          CFG_WIN = 128,
    parameter int          RST_DLY = 128,
    parameter int          PRE_DIV = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  clk_ticks,
    input  logic              in_wait,
    input  logic              in_stop,
    input  logic              in_debug,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] tov_q, win_q, cnt_q;
    logic             cfg_open, hit, flag, tripped;
    logic             en_q, int_en_q;
    logic             unlock_ok, refresh_ok, key_err, early, run, flag_clr, kwr;
    key_evt_t         kevt;

    assign en_q     = ctrl.en;
    assign int_en_q = ctrl.int_en;
    assign kwr      = bus_wr && (bus_addr == A_CNT);

    kww_keycheck #(.REF_KEY(REF_KEY), .UNL_KEY(UNL_KEY)) u_key (
        .clk(clk), .rst(rst), .cmd32(ctrl.cmd32),
        .kwr(kwr), .kdata(bus_wdata), .evt(kevt)
    );

    assign unlock_ok  = kevt.unlock;
    assign early      = ctrl.win_en && (cnt_q < win_q);
    assign refresh_ok = kevt.refresh && en_q && !tripped && !early;
    assign key_err    = kevt.err || (kevt.refresh && early);
    assign run        = en_q && !(in_wait && !ctrl.wait_en)
                             && !(in_stop && !ctrl.stop_en)
                             && !(in_debug && !ctrl.dbg_en);
    assign flag_clr   = bus_wr && (bus_addr == A_STAT) && bus_wdata[1];

    kww_cfg #(.CFG_WIN(CFG_WIN)) u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[15:0]), .unlock(unlock_ok),
        .ctrl(ctrl), .tov(tov_q), .win(win_q), .cfg_open(cfg_open)
    );

    kww_counter #(.N_SRC(N_SRC), .PRE_DIV(PRE_DIV), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
        .clk(clk), .rst(rst), .ticks(clk_ticks), .sel(ctrl.clk_sel),
        .pre_on(ctrl.pre256), .run(run), .clear(refresh_ok), .hold(tripped),
        .limit(tov_q), .cnt(cnt_q), .hit(hit)
    );

    kww_trip #(.RST_DLY(RST_DLY)) u_trip (
        .clk(clk), .rst(rst), .en(en_q), .int_en(int_en_q), .hit(hit),
        .err(key_err), .flag_clr(flag_clr), .flag(flag),
        .rst_req(rst_req), .tripped(tripped)
    );

    assign irq = flag && int_en_q;

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {16'h0, ctrl};
            A_CNT:   bus_rdata = {16'h0, cnt_q};
            A_TOV:   bus_rdata = {16'h0, tov_q};
            A_WIN:   bus_rdata = {16'h0, win_q};
            A_STAT:  bus_rdata = {29'h0, cfg_open, flag, en_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/kww_chk.sv
module kww_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        int_en,
    input logic [15:0] cnt,
    input logic        cfg_open,
    input logic        unlock,
    input logic        refresh_ok,
    input logic        key_err,
    input logic        tripped,
    input logic        irq,
    input logic        rst_req
);
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    // R4
    refresh_zero_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_ok |=> (cnt == 16'h0));

    // R5
    open_needs_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(unlock));

    // R10
    reset_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req);

    // R11
    err_fast_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (key_err && en && !tripped && !int_en) |=> rst_req);

    // R9
    irq_before_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !rst_req);
endmodule

bind kww_top kww_chk u_chk (
    .clk(clk), .rst(rst), .en(en_q), .int_en(int_en_q), .cnt(cnt_q),
    .cfg_open(cfg_open), .unlock(unlock_ok), .refresh_ok(refresh_ok),
    .key_err(key_err), .tripped(tripped), .irq(irq), .rst_req(rst_req)
);

// File: tb/sim_kww_top.sv
module sim_kww_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] REF = 32'h6B9F_0471;
    localparam logic [31:0] UNL = 32'hC3A5_1E2D;

    logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  clk_ticks = '0;
    logic        in_wait = 1'b0, in_stop = 1'b0, in_debug = 1'b0;
    logic        irq, rst_req;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kww_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_ticks(clk_ticks),
        .in_wait(in_wait), .in_stop(in_stop), .in_debug(in_debug),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; clk_ticks = '0;
        in_wait = 1'b0; in_stop = 1'b0; in_debug = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int src, input int n);
        clk_ticks = 4'(1 << src);
        repeat (n) @(negedge clk);
        clk_ticks = '0;
    endtask

    task automatic key16(input logic [31:0] k);
        wr(3'd1, {16'h0, k[15:0]});
        wr(3'd1, {16'h0, k[31:16]});
    endtask

    task automatic t_reset_r1;
        logic [31:0] d;
        do_reset;
        rd(3'd0, d); chk("R1 ctrl", d, 32'h9);
        rd(3'd2, d); chk("R1 timeout", d, 32'hFFFF);
        rd(3'd3, d); chk("R1 window", d, 32'h0);
        rd(3'd1, d); chk("R1 counter", d, 32'h0);
        rd(3'd4, d); chk("R1 status", d, 32'h1);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_write_once_r2;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h1);
        wr(3'd2, 32'd20);
        rd(3'd2, d); chk("R2 first write", d, 32'd20);
        wr(3'd2, 32'd33);
        rd(3'd2, d); chk("R2 second write ignored", d, 32'd20);
        key16(UNL);
        wr(3'd2, 32'd44);
        rd(3'd2, d); chk("R2 no update permit", d, 32'd20);
        wr(3'd0, 32'hB);
        rd(3'd0, d); chk("R2 ctrl locked", d, 32'h1);
    endtask

    task automatic t_count_r3;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h89);
        tick(2, 5);
        rd(3'd1, d); chk("R3 selected source", d, 32'd5);
        tick(0, 3);
        rd(3'd1, d); chk("R3 other source", d, 32'd5);
        key16(UNL);
        wr(3'd0, 32'h88);
        rd(3'd4, d); chk("R3 running bit off", d & 32'h1, 32'h0);
        tick(2, 4);
        rd(3'd1, d); chk("R3 disabled holds", d, 32'd5);
    endtask

    task automatic t_refresh_r4;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h9);
        tick(0, 7);
        wr(3'd1, {16'h0, REF[15:0]});
        rd(3'd1, d); chk("R4 half key no effect", d, 32'd7);
        wr(3'd1, {16'h0, REF[31:16]});
        rd(3'd1, d); chk("R4 refresh clears", d, 32'd0);
        chk("R4 no reset", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_unlock_r5_r6;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h9);
        wr(3'd2, 32'd100);
        key16(UNL);
        rd(3'd4, d); chk("R5 window open", d, 32'h5);
        wr(3'd2, 32'd200);
        rd(3'd2, d); chk("R5 write in window", d, 32'd200);
        wr(3'd2, 32'd300);
        rd(3'd2, d); chk("R5 one write per window", d, 32'd200);
        repeat (130) @(negedge clk);
        rd(3'd4, d); chk("R6 window closed", d, 32'h1);
        wr(3'd2, 32'd400);
        rd(3'd2, d); chk("R6 late write ignored", d, 32'd200);
        key16(UNL);
        repeat (127) @(negedge clk);
        wr(3'd2, 32'd600);
        rd(3'd2, d); chk("R5 last clock of window", d, 32'd600);
        key16(UNL);
        repeat (128) @(negedge clk);
        wr(3'd2, 32'd700);
        rd(3'd2, d); chk("R6 first clock after window", d, 32'd600);
    endtask

    task automatic t_prescale_r7;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h29);
        tick(0, 255);
        rd(3'd1, d); chk("R7 255 ticks", d, 32'd0);
        tick(0, 1);
        rd(3'd1, d); chk("R7 256 ticks", d, 32'd1);
        tick(0, 256);
        rd(3'd1, d); chk("R7 512 ticks", d, 32'd2);
    endtask

    task automatic t_modes_r8;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h109);
        in_wait = 1'b1;
        tick(0, 3);
        rd(3'd1, d); chk("R8 wait permitted", d, 32'd3);
        in_stop = 1'b1;
        tick(0, 3);
        rd(3'd1, d); chk("R8 stop blocks", d, 32'd3);
        in_stop = 1'b0; in_debug = 1'b1;
        tick(0, 2);
        rd(3'd1, d); chk("R8 debug blocks", d, 32'd3);
        in_debug = 1'b0; in_wait = 1'b0;
    endtask

    task automatic t_timeout_r9_r10;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'hB);
        wr(3'd2, 32'd4);
        tick(0, 4);
        rd(3'd1, d); chk("R9 counter at timeout", d, 32'd4);
        chk("R9 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq raised", {31'h0, irq}, 32'h1);
        rd(3'd4, d); chk("R9 flag set", d & 32'h2, 32'h2);
        chk("R10 no reset yet", {31'h0, rst_req}, 32'h0);
        wr(3'd4, 32'h2);
        rd(3'd4, d); chk("R9 flag cleared", d & 32'h2, 32'h0);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        repeat (126) @(negedge clk);
        chk("R10 reset at 127", {31'h0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R10 reset at 128", {31'h0, rst_req}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R10 reset sticky", {31'h0, rst_req}, 32'h1);
        do_reset;
        wr(3'd0, 32'h9);
        wr(3'd2, 32'd2);
        tick(0, 2);
        chk("R10 no int pre", {31'h0, rst_req}, 32'h0);
        @(negedge clk);
        chk("R10 no int immediate", {31'h0, rst_req}, 32'h1);
        chk("R10 no irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_badkey_r11;
        do_reset;
        wr(3'd0, 32'h9);
        wr(3'd1, {16'h0, REF[15:0]});
        chk("R11 half pending", {31'h0, rst_req}, 32'h0);
        wr(3'd1, {16'h0, UNL[31:16]});
        chk("R11 broken sequence", {31'h0, rst_req}, 32'h1);
        do_reset;
        wr(3'd0, 32'h9);
        wr(3'd1, 32'h1234);
        chk("R11 wrong low half", {31'h0, rst_req}, 32'h1);
        do_reset;
        wr(3'd0, 32'hB);
        wr(3'd1, 32'h1234);
        chk("R11 error with int irq", {31'h0, irq}, 32'h1);
        chk("R11 error with int delayed", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_window_r12;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'hD);
        wr(3'd3, 32'd10);
        wr(3'd2, 32'd50);
        tick(0, 3);
        key16(REF);
        chk("R12 early refresh trips", {31'h0, rst_req}, 32'h1);
        do_reset;
        wr(3'd0, 32'hD);
        wr(3'd3, 32'd10);
        wr(3'd2, 32'd50);
        tick(0, 10);
        key16(REF);
        rd(3'd1, d); chk("R12 refresh at window value", d, 32'd0);
        chk("R12 no reset", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_cmd32_r13;
        logic [31:0] d;
        do_reset;
        wr(3'd0, 32'h19);
        tick(0, 6);
        wr(3'd1, REF);
        rd(3'd1, d); chk("R13 single write refresh", d, 32'd0);
        chk("R13 no reset", {31'h0, rst_req}, 32'h0);
        wr(3'd1, UNL);
        rd(3'd4, d); chk("R13 single write unlock", d, 32'h5);
        wr(3'd1, {16'h0, REF[15:0]});
        chk("R13 half key is error", {31'h0, rst_req}, 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_r1;
        t_write_once_r2;
        t_count_r3;
        t_refresh_r4;
        t_unlock_r5_r6;
        t_prescale_r7;
        t_modes_r8;
        t_timeout_r9_r10;
        t_badkey_r11;
        t_window_r12;
        t_cmd32_r13;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule